// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block is a clocked register for the address and command lines of a memory module. On each rising clock edge it samples a 28-bit command word and drives it out twice, on an A bank and on a B bank, so that two sets of loads can be fed from one source. Two active-low select inputs gate the command outputs. While neither select is asserted, the outputs keep their last value, so the downstream nets do not toggle. A gating-enable input turns this hold off, and the outputs then follow the input every cycle. The clock-enable and termination-control lines are registered into both banks on every edge, whatever the selects are.

A parity checker runs beside the data path. The controller sends an odd-parity bit for the low 22 command bits one clock after the word it covers. The block keeps the word for one stage, combines it with the late parity bit, and signals a mismatch on a registered, active-low error output. Each mismatch holds the output low for a stretch of cycles. A synchronous active-low reset clears every output and releases the error flag.

Top module: `cmd_regbuf`

## Requirements
- R1: The A bank and B bank command outputs always carry the same value, which is a word sampled from `cmd_in` on a rising clock edge.
- R2: While `rst_n` is low at a rising edge, every command, clock-enable and termination output becomes 0 and `err_n` becomes 1, whatever the selects, gating enable or parity input are.
- R3: The clock-enable and termination outputs of both banks take the value of `cke_in` and `odt_in` at every rising edge out of reset, independent of `sel_n` and `gate_en`.
- R4: With `gate_en` = 1, the command outputs load `cmd_in` at an edge where `sel_n[0]` or `sel_n[1]` is 0. When both bits are 1 they keep their previous value.
- R5: With `gate_en` = 0, the command outputs load `cmd_in` at every edge out of reset, whatever `sel_n` is.
- R6: Parity is odd over `cmd_in[21:0]`. The parity bit sampled at edge k+1 is paired with the word sampled at edge k. A mismatch is detected when the XOR of those 22 bits and the parity bit equals 0.
- R7: A mismatch detected at an edge drives `err_n` low right after that edge and keeps it low for exactly 2 cycles. A further mismatch inside that window restarts the 2-cycle count.
- R8: At the first edge after reset is released, no word has been paired yet, so no mismatch is reported at that edge. The first check happens at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_en | input | 1 | 1 = select gating of command outputs enabled |
| sel_n | input | 2 | Active-low select inputs |
| cmd_in | input | 28 | Command/address word |
| cke_in | input | 2 | Clock-enable lines (ungated) |
| odt_in | input | 2 | Termination-control lines (ungated) |
| par_in | input | 1 | Odd parity for `cmd_in[21:0]` of the previous cycle |
| cmd_a | output | 28 | Command outputs, bank A |
| cmd_b | output | 28 | Command outputs, bank B |
| cke_a | output | 2 | Clock-enable outputs, bank A |
| cke_b | output | 2 | Clock-enable outputs, bank B |
| odt_a | output | 2 | Termination outputs, bank A |
| odt_b | output | 2 | Termination outputs, bank B |
| err_n | output | 1 | Parity error flag, active low |

## Verification
Two pairs of functions can act at the same edge. The first pair is a select hold on the command outputs together with a parity check of the previous word: a deselected word still reaches the parity pipeline. The second pair is reset together with a running error window: reset must clear the window at once, and the first edge after reset must not report anything. Directed sequences set these up on purpose: a bad parity bit sent while both selects are high, a reset placed in the middle of a low error window, and a wrong parity bit on the first edge after reset. After these, a long run with seeded random stimulus mixes selects, gating enable, parity faults and occasional resets. A bench reference model computes the expected value of each output every cycle, and the outputs are compared with it a nanosecond after each edge.

// File: rtl/cmd_regbuf_pkg.sv
// Package: shared sizes and the parity helper for the registered command buffer.
// Assumes: parity is odd and covers the low PAR_W bits of the command word.
package cmd_regbuf_pkg;
    localparam int unsigned CMD_W_DEF  = 28;
    localparam int unsigned PAR_W_DEF  = 22;
    localparam int unsigned LINE_W_DEF = 2;
    localparam int unsigned HOLD_DEF   = 2;

    // Returns 1 when the word bits plus the parity bit fail odd parity.
    function automatic logic odd_par_fail(input logic [PAR_W_DEF-1:0] bits, input logic par);
        return ~((^bits) ^ par);
    endfunction
endpackage

// File: rtl/cmd_gate_reg.sv
// Module: gated command register with one copy per output bank.
// Loads the command word when selected (or when gating is off), otherwise holds.
// Assumes: synchronous active-low reset, which overrides the selects.
module cmd_gate_reg #(
    parameter int unsigned CMD_W  = 28,
    parameter int unsigned BANKS  = 2,
    parameter int unsigned SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic [SEL_W-1:0] sel_n,
    input  logic [CMD_W-1:0] cmd_in,
    output logic [CMD_W-1:0] cmd_q [BANKS]
);
    logic load;

    // Decide whether this edge updates the gated outputs.
    always_comb begin
        load = !gate_en || !(&sel_n);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // One register copy per bank, loaded together.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmd_q[b] <= '0;
            else if (load)
                cmd_q[b] <= cmd_in;
        end
    end

    AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && (&sel_n)) |=> $stable(cmd_q[0])) else $error("hold"); // R4
    AST_LOAD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en || !(&sel_n)) |=> (cmd_q[0] == $past(cmd_in))) else $error("load"); // R5
    AST_BANKS_MATCH: assert property (@(posedge clk)
        cmd_q[0] == cmd_q[BANKS-1]) else $error("banks"); // R1
    AST_CMD_RESET: assert property (@(posedge clk)
        !rst_n |=> (cmd_q[0] == '0)) else $error("reset"); // R2
endmodule

// File: rtl/side_line_reg.sv
// Module: ungated register for clock-enable and termination lines, one copy per bank.
// Assumes: these lines update every edge, whatever the selects are.
module side_line_reg #(
    parameter int unsigned LINE_W = 2,
    parameter int unsigned BANKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] cke_in,
    input  logic [LINE_W-1:0] odt_in,
    output logic [LINE_W-1:0] cke_q [BANKS],
    output logic [LINE_W-1:0] odt_q [BANKS]
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Register both side lines into this bank every edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cke_q[b] <= '0;
                odt_q[b] <= '0;
            end else begin
                cke_q[b] <= cke_in;
                odt_q[b] <= odt_in;
            end
        end
    end

    AST_SIDE_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_q[0] == $past(cke_in) && odt_q[BANKS-1] == $past(odt_in))) else $error("side"); // R3
endmodule

// File: rtl/par_check.sv
// Module: parity pipeline. Keeps the word one stage, pairs it with the late
// parity bit, and stretches each mismatch into an active-low error window.
// Assumes: parity for the word sampled at edge k is sampled at edge k+1.
module par_check
    import cmd_regbuf_pkg::*;
#(
    parameter int unsigned PAR_W = 22,
    parameter int unsigned HOLD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAR_W-1:0] bits_in,
    input  logic             par_in,
    output logic             err_n
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);

    logic [PAR_W-1:0] bits_d;
    logic             bits_vld;
    logic             fail;
    logic [CNT_W-1:0] win_cnt;

    // Store the covered bits and mark that a word is waiting for its parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_d   <= '0;
            bits_vld <= 1'b0;
        end else begin
            bits_d   <= bits_in;
            bits_vld <= 1'b1;
        end
    end

    // Compare the stored word with the parity bit that is arriving now.
    always_comb begin
        fail = bits_vld && odd_par_fail(bits_d, par_in);
    end

    // Restart the error window on each mismatch and count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (fail)
            win_cnt <= CNT_W'(HOLD);
        else if (win_cnt != '0)
            win_cnt <= win_cnt - 1'b1;
    end

    // Registered flag output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_n <= 1'b1;
        else
            err_n <= !(fail || (win_cnt > CNT_W'(1)));
    end

    AST_ERR_RESET: assert property (@(posedge clk)
        !rst_n |=> err_n) else $error("err reset"); // R2
    AST_NO_EARLY_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        !bits_vld |=> err_n) else $error("early"); // R8
    AST_ERR_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n) else $error("short"); // R7
    AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !err_n) else $error("missed"); // R6
endmodule

// File: rtl/cmd_regbuf.sv
// Module: registered command buffer, top level. Two output banks for the
// command word (select gated) and for the side lines (ungated), plus parity.
// Assumes: one clock domain, synchronous active-low reset.
module cmd_regbuf
    import cmd_regbuf_pkg::*;
#(
    parameter int unsigned CMD_W  = CMD_W_DEF,
    parameter int unsigned PAR_W  = PAR_W_DEF,
    parameter int unsigned LINE_W = LINE_W_DEF,
    parameter int unsigned HOLD   = HOLD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic [1:0]        sel_n,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic [LINE_W-1:0] cke_in,
    input  logic [LINE_W-1:0] odt_in,
    input  logic              par_in,
    output logic [CMD_W-1:0]  cmd_a,
    output logic [CMD_W-1:0]  cmd_b,
    output logic [LINE_W-1:0] cke_a,
    output logic [LINE_W-1:0] cke_b,
    output logic [LINE_W-1:0] odt_a,
    output logic [LINE_W-1:0] odt_b,
    output logic              err_n
);
    localparam int unsigned BANKS = 2;

    logic [CMD_W-1:0]  cmd_q [BANKS];
    logic [LINE_W-1:0] cke_q [BANKS];
    logic [LINE_W-1:0] odt_q [BANKS];

    cmd_gate_reg #(.CMD_W(CMD_W), .BANKS(BANKS), .SEL_W(2)) u_cmd (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .sel_n(sel_n),
        .cmd_in(cmd_in), .cmd_q(cmd_q)
    );

    side_line_reg #(.LINE_W(LINE_W), .BANKS(BANKS)) u_side (
        .clk(clk), .rst_n(rst_n), .cke_in(cke_in), .odt_in(odt_in),
        .cke_q(cke_q), .odt_q(odt_q)
    );

    par_check #(.PAR_W(PAR_W), .HOLD(HOLD)) u_par (
        .clk(clk), .rst_n(rst_n), .bits_in(cmd_in[PAR_W-1:0]),
        .par_in(par_in), .err_n(err_n)
    );

    // Map bank copies onto the named ports.
    always_comb begin
        cmd_a = cmd_q[0];
        cmd_b = cmd_q[1];
        cke_a = cke_q[0];
        cke_b = cke_q[1];
        odt_a = odt_q[0];
        odt_b = odt_q[1];
    end
endmodule

// File: tb/test_cmd_regbuf.sv
module test_cmd_regbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_en = 1'b1;
    logic [1:0]  sel_n = 2'b11;
    logic [27:0] cmd_in = '0;
    logic [1:0]  cke_in = '0;
    logic [1:0]  odt_in = '0;
    logic        par_in = 1'b0;
    logic [27:0] cmd_a, cmd_b;
    logic [1:0]  cke_a, cke_b, odt_a, odt_b;
    logic        err_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [27:0] m_cmd = '0;
    logic [1:0]  m_cke = '0, m_odt = '0;
    logic [21:0] m_prev = '0;
    bit          m_vld = 0;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    cmd_regbuf i_cmd_regbuf (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .sel_n(sel_n),
        .cmd_in(cmd_in), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .cke_a(cke_a), .cke_b(cke_b),
        .odt_a(odt_a), .odt_b(odt_b), .err_n(err_n)
    );

    function automatic logic good_par(input logic [27:0] w);
        return ~(^w[21:0]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, and check after the edge.
    task automatic step(input bit r, input bit ge, input logic [1:0] s,
                        input logic [27:0] c, input logic [1:0] k,
                        input logic [1:0] o, input logic p);
        bit fail;
        @(negedge clk);
        rst_n = r; gate_en = ge; sel_n = s; cmd_in = c; cke_in = k; odt_in = o; par_in = p;
        if (!r) begin
            m_cmd = '0; m_cke = '0; m_odt = '0; m_vld = 0; m_cnt = 0;
        end else begin
            if (!ge || !(&s)) m_cmd = c;
            m_cke = k; m_odt = o;
            fail = m_vld && ((^m_prev) == p);
            if (fail) m_cnt = 2;
            else if (m_cnt > 0) m_cnt--;
            m_prev = c[21:0]; m_vld = 1;
        end
        @(posedge clk); #1;
        if (!r) begin
            chk("R2 cmd_a", 32'(cmd_a), 32'(0));
            chk("R2 side", {28'(0), cke_b, odt_a}, 32'(0));
            chk("R2 err_n", 32'(err_n), 32'(1));
        end else begin
            chk(ge ? "R4 cmd_a" : "R5 cmd_a", 32'(cmd_a), 32'(m_cmd));
            chk("R1 cmd_b", 32'(cmd_b), 32'(m_cmd));
            chk("R3 side", {24'(0), cke_a, cke_b, odt_a, odt_b}, {24'(0), m_cke, m_cke, m_odt, m_odt});
            chk("R6 R7 R8 err_n", 32'(err_n), 32'(m_cnt == 0));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [27:0] w;
        void'($urandom(1234));
        // R2: reset with selects active and a bad parity bit
        step(0, 1, 2'b00, 28'hFFF_FFFF, 2'b11, 2'b11, 1'b0);
        step(0, 0, 2'b00, 28'hABC_DEF1, 2'b11, 2'b11, 1'b1);
        // R8: first edge after reset with wrong parity is not reported
        step(1, 1, 2'b10, 28'h123_4567, 2'b01, 2'b10, ~good_par(28'h0));
        step(1, 1, 2'b01, 28'h765_4321, 2'b10, 2'b01, good_par(28'h123_4567));
        // R4: deselected word held, its parity still checked (bad) -> R6, R7
        step(1, 1, 2'b11, 28'h0F0_F0F0, 2'b11, 2'b00, good_par(28'h765_4321));
        step(1, 1, 2'b11, 28'h1111111, 2'b00, 2'b11, ~good_par(28'h0F0_F0F0));
        step(1, 1, 2'b11, 28'h2222222, 2'b00, 2'b11, good_par(28'h1111111));
        step(1, 1, 2'b11, 28'h3333333, 2'b00, 2'b11, good_par(28'h2222222));
        // R7: back-to-back errors extend the window
        step(1, 1, 2'b00, 28'h4444444, 2'b01, 2'b01, ~good_par(28'h3333333));
        step(1, 1, 2'b00, 28'h5555555, 2'b01, 2'b01, good_par(28'h4444444));
        step(1, 1, 2'b00, 28'h6666666, 2'b01, 2'b01, ~good_par(28'h5555555));
        step(1, 1, 2'b00, 28'h7777777, 2'b01, 2'b01, good_par(28'h6666666));
        step(1, 1, 2'b00, 28'h8888888, 2'b01, 2'b01, good_par(28'h7777777));
        // R5: gating off, deselected still loads
        step(1, 0, 2'b11, 28'h9999999, 2'b10, 2'b10, good_par(28'h8888888));
        step(1, 0, 2'b11, 28'hAAAAAAA, 2'b10, 2'b10, ~good_par(28'h9999999));
        // R2: reset in the middle of an error window clears it
        step(0, 0, 2'b11, 28'hBBBBBBB, 2'b10, 2'b10, 1'b0);
        step(1, 1, 2'b11, 28'hCCCCCCC, 2'b11, 2'b11, 1'b0);
        // random phase
        w = 28'hCCCCCCC;
        for (int i = 0; i < 3000; i++) begin
            logic [27:0] c;
            logic        p;
            c = 28'($urandom());
            p = (($urandom() % 5) == 0) ? ~good_par(w) : good_par(w);
            step((($urandom() % 100) != 0), (($urandom() % 4) != 0), 2'($urandom()),
                 c, 2'($urandom()), 2'($urandom()), p);
            w = c;
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule